// File: doc/BRIEF.md
# Offset Register Load and Readback Sequencer

This block sits beside a FIFO's storage array and owns the two threshold registers that the almost-empty and almost-full flag comparators use. Software programs or inspects those thresholds through the FIFO's ordinary data ports. While the active-low load select is held low, an enabled write stores the input word into the next threshold piece, and an enabled read puts the next piece onto the output port. While the load select is high, the same enables are passed on to the FIFO as memory accesses. The block keeps one pointer for writes and a separate pointer for reads. Each pointer moves through the pieces in a fixed circular order.

The port can run word-wide or byte-wide. In word-wide mode each threshold register is split into two pieces, so a full pass takes four accesses. In byte-wide mode each register is split into three pieces, so a full pass takes six. Threshold programming may be paused at any point, interleaved with FIFO traffic, and resumed later. Each flag is marked not valid while its own threshold is being rewritten. The block reports a read that follows another read too closely, and a read that coincides with a write; both are kept as sticky errors. A master reset restores the default thresholds and both pointers. A partial reset clears only the error bits.

Top module: `offset_prog_seq`

## Requirements
- R1: After master reset (`rst_n` low), both pointers address piece 0 of the empty threshold. The thresholds equal `DEF_EMPTY` and `DEF_FULL`. Both flag-valid outputs are high, both error bits are low, and `dout_valid` is low.
- R2: In word mode (`byte_mode`=0), each write with `ld_n`=0 and `wen_n`=0 fills the next piece in this circular order: empty piece 0, empty piece 1, full piece 0, full piece 1. Piece 0 holds threshold bits [15:0], taken from `din[15:0]`. Piece 1 holds bits [23:16], taken from `din[7:0]`. After full piece 1, the next write goes to empty piece 0 again.
- R3: In byte mode (`byte_mode`=1), each threshold has three pieces holding bits [7:0], [15:8] and [23:16], each taken from `din[7:0]`. The order is empty 0, 1, 2, then full 0, 1, 2, then back to empty 0.
- R4: An offset read (`ld_n`=0, `ren_n`=0) that is accepted drives the piece at the read pointer, zero-extended, onto `dout`, with `dout_valid` high, one cycle later. The read pointer then advances in the same order as the write pointer.
- R5: An offset read attempted in the cycle right after another offset read attempt is ignored. `dout_valid` stays low, the read pointer holds, and the sticky `err_b2b` is set.
- R6: When an offset write and an offset read are attempted in the same cycle, the write is performed, the read is ignored, and the sticky `err_collide` is set.
- R7: With `ld_n`=1, `wr_to_mem` follows `!wen_n` and `rd_from_mem` follows `!ren_n`. Thresholds and pointers are left unchanged, and programming later resumes at the next piece. With `ld_n`=0, `wr_to_ofs` follows `!wen_n` and `wr_to_mem` is low.
- R8: A write to any piece of a threshold lowers that threshold's valid flag at the next edge. After the write of its last piece, the flag rises at the second edge following that write. The other flag is not affected.
- R9: With `prst_n` low, the next edge clears both error bits and `dout_valid`. Pointers and thresholds are kept.
- R10: The write pointer and the read pointer move independently; a write never moves the read pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for writes and reads |
| rst_n | input | 1 | Asynchronous master reset, active low |
| prst_n | input | 1 | Synchronous partial reset, active low |
| byte_mode | input | 1 | 1 = byte-wide port, 0 = word-wide port |
| ld_n | input | 1 | Load select, active low: steer accesses to thresholds |
| wen_n | input | 1 | Write enable, active low |
| ren_n | input | 1 | Read enable, active low |
| din | input | DATA_W | Write data |
| wr_to_mem | output | 1 | Write is routed to FIFO memory |
| rd_from_mem | output | 1 | Read is routed to FIFO memory |
| wr_to_ofs | output | 1 | Write is routed to a threshold piece |
| dout | output | DATA_W | Threshold piece read back |
| dout_valid | output | 1 | `dout` carries a fresh piece |
| empty_ofs | output | OFS_W | Almost-empty threshold |
| full_ofs | output | OFS_W | Almost-full threshold |
| aempty_valid | output | 1 | Almost-empty threshold is complete and usable |
| afull_valid | output | 1 | Almost-full threshold is complete and usable |
| err_b2b | output | 1 | Sticky: a read came too close after another read |
| err_collide | output | 1 | Sticky: threshold read and write in the same cycle |

## Verification
A threshold write and a threshold read can fall on the same edge. The bench provokes this by holding `ld_n`, `wen_n` and `ren_n` low together for one cycle. It then judges the outcome at the ports: `err_collide` must be set and no readback must appear. Two later, properly spaced reads must return first the word that was written and then the following piece, which shows that the write landed and the read pointer did not move. A separate scenario checks the other timing hazard, a read attempt on the edge right after another read attempt.

// File: rtl/offset_prog_pkg.sv
package offset_prog_pkg;

    // Pointer into the threshold pieces: which register, which piece
    typedef struct packed {
        logic       reg_sel;   // 0 = empty threshold, 1 = full threshold
        logic [1:0] piece;
    } ptr_t;

    // Validity tracker state for one threshold register
    typedef struct packed {
        logic       valid;
        logic [3:0] cnt;
    } vld_t;

endpackage

// File: rtl/offset_prog_ptr.sv
module offset_prog_ptr
    import offset_prog_pkg::*;
#(
    parameter int LAST_B = 2,
    parameter int LAST_W = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic step,
    input  logic byte_mode,
    output ptr_t ptr
);

    ptr_t ptr_d, ptr_q;
    logic [1:0] last;

    always_comb begin
        last  = byte_mode ? 2'(LAST_B) : 2'(LAST_W);
        ptr_d = ptr_q;
        if (step) begin
            if (ptr_q.piece >= last) begin
                ptr_d.piece   = 2'd0;
                ptr_d.reg_sel = ~ptr_q.reg_sel;
            end else begin
                ptr_d.piece = ptr_q.piece + 2'd1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end

    assign ptr = ptr_q;

endmodule

// File: rtl/offset_prog_vld.sv
module offset_prog_vld
    import offset_prog_pkg::*;
#(
    parameter int DLY = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_piece,
    input  logic wr_last,
    output logic valid
);

    vld_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_piece) begin
            st_d.valid = 1'b0;
            st_d.cnt   = wr_last ? 4'(DLY) : 4'd0;
        end else if (st_q.cnt != 4'd0) begin
            st_d.cnt = st_q.cnt - 4'd1;
            if (st_q.cnt == 4'd1) st_d.valid = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{valid: 1'b1, cnt: 4'd0};
        else        st_q <= st_d;
    end

    assign valid = st_q.valid;

endmodule

// File: rtl/offset_prog_seq.sv
module offset_prog_seq
    import offset_prog_pkg::*;
#(
    parameter int              DATA_W    = 16,
    parameter int              BYTE_W    = 8,
    parameter int              OFS_W     = 24,
    parameter int              VLD_DLY   = 2,
    parameter logic [OFS_W-1:0] DEF_EMPTY = 24'h030007,
    parameter logic [OFS_W-1:0] DEF_FULL  = 24'h050009
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prst_n,
    input  logic              byte_mode,
    input  logic              ld_n,
    input  logic              wen_n,
    input  logic              ren_n,
    input  logic [DATA_W-1:0] din,
    output logic              wr_to_mem,
    output logic              rd_from_mem,
    output logic              wr_to_ofs,
    output logic [DATA_W-1:0] dout,
    output logic              dout_valid,
    output logic [OFS_W-1:0]  empty_ofs,
    output logic [OFS_W-1:0]  full_ofs,
    output logic              aempty_valid,
    output logic              afull_valid,
    output logic              err_b2b,
    output logic              err_collide
);

    localparam int LAST_B = (OFS_W + BYTE_W - 1) / BYTE_W - 1;
    localparam int LAST_W = (OFS_W + DATA_W - 1) / DATA_W - 1;

    typedef struct packed {
        logic [OFS_W-1:0]  empty_ofs;
        logic [OFS_W-1:0]  full_ofs;
        logic [DATA_W-1:0] dout;
        logic              dout_valid;
        logic              rd_prev;
        logic              err_b2b;
        logic              err_col;
    } st_t;

    st_t  st_d, st_q;
    ptr_t wptr, rptr;
    logic ofs_wr, rd_try, rd_ok;
    logic [1:0] last_piece;
    logic [1:0] wr_hit;
    logic [1:0] wr_is_last;

    // Insert one data piece into a threshold register
    function automatic logic [OFS_W-1:0] put_piece(
        input logic [OFS_W-1:0]  cur,
        input logic [1:0]        pc,
        input logic              bm,
        input logic [DATA_W-1:0] d
    );
        logic [OFS_W-1:0] r;
        r = cur;
        for (int i = 0; i < OFS_W; i++) begin
            if (bm) begin
                if ((i / BYTE_W) == int'(pc)) r[i] = d[i % BYTE_W];
            end else begin
                if ((i / DATA_W) == int'(pc)) r[i] = d[i % DATA_W];
            end
        end
        return r;
    endfunction

    // Extract one piece of a threshold register, zero-extended
    function automatic logic [DATA_W-1:0] get_piece(
        input logic [OFS_W-1:0] cur,
        input logic [1:0]       pc,
        input logic             bm
    );
        logic [DATA_W-1:0] o;
        int idx;
        o = '0;
        for (int j = 0; j < DATA_W; j++) begin
            if (bm) idx = int'(pc) * BYTE_W + j;
            else    idx = int'(pc) * DATA_W + j;
            if ((!bm || j < BYTE_W) && idx < OFS_W) o[j] = cur[idx];
        end
        return o;
    endfunction

    // Access steering
    always_comb begin
        ofs_wr     = !ld_n && !wen_n;
        rd_try     = !ld_n && !ren_n;
        rd_ok      = rd_try && !st_q.rd_prev && !ofs_wr;
        last_piece = byte_mode ? 2'(LAST_B) : 2'(LAST_W);
    end

    // Next-state computation
    always_comb begin
        st_d = st_q;
        st_d.rd_prev    = rd_try;
        st_d.dout_valid = rd_ok;
        if (ofs_wr) begin
            if (!wptr.reg_sel)
                st_d.empty_ofs = put_piece(st_q.empty_ofs, wptr.piece, byte_mode, din);
            else
                st_d.full_ofs  = put_piece(st_q.full_ofs, wptr.piece, byte_mode, din);
        end
        if (rd_ok) begin
            st_d.dout = get_piece(rptr.reg_sel ? st_q.full_ofs : st_q.empty_ofs,
                                  rptr.piece, byte_mode);
        end
        if (rd_try && st_q.rd_prev) st_d.err_b2b = 1'b1;
        if (rd_try && ofs_wr)       st_d.err_col = 1'b1;
        if (!prst_n) begin
            st_d.err_b2b    = 1'b0;
            st_d.err_col    = 1'b0;
            st_d.dout_valid = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{empty_ofs: DEF_EMPTY, full_ofs: DEF_FULL, dout: '0,
                      dout_valid: 1'b0, rd_prev: 1'b0, err_b2b: 1'b0, err_col: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    offset_prog_ptr #(.LAST_B(LAST_B), .LAST_W(LAST_W)) u_wptr (
        .clk(clk), .rst_n(rst_n), .step(ofs_wr), .byte_mode(byte_mode), .ptr(wptr)
    );

    offset_prog_ptr #(.LAST_B(LAST_B), .LAST_W(LAST_W)) u_rptr (
        .clk(clk), .rst_n(rst_n), .step(rd_ok), .byte_mode(byte_mode), .ptr(rptr)
    );

    // One validity tracker per threshold register
    logic [1:0] vld_out;
    for (genvar g = 0; g < 2; g++) begin : g_vld
        assign wr_hit[g]     = ofs_wr && (wptr.reg_sel == 1'(g));
        assign wr_is_last[g] = (wptr.piece >= last_piece);
        offset_prog_vld #(.DLY(VLD_DLY)) u_vld (
            .clk(clk), .rst_n(rst_n), .wr_piece(wr_hit[g]),
            .wr_last(wr_is_last[g]), .valid(vld_out[g])
        );
    end

    assign wr_to_mem    = ld_n && !wen_n;
    assign rd_from_mem  = ld_n && !ren_n;
    assign wr_to_ofs    = ofs_wr;
    assign dout         = st_q.dout;
    assign dout_valid   = st_q.dout_valid;
    assign empty_ofs    = st_q.empty_ofs;
    assign full_ofs     = st_q.full_ofs;
    assign aempty_valid = vld_out[0];
    assign afull_valid  = vld_out[1];
    assign err_b2b      = st_q.err_b2b;
    assign err_collide  = st_q.err_col;

endmodule

// File: rtl/offset_prog_chk.sv
module offset_prog_chk #(
    parameter int OFS_W = 24
) (
    input logic             clk,
    input logic             rst_n,
    input logic             prst_n,
    input logic             ld_n,
    input logic             wen_n,
    input logic             ren_n,
    input logic             dout_valid,
    input logic             err_b2b,
    input logic             err_collide,
    input logic             aempty_valid,
    input logic             wr_to_mem,
    input logic             wr_to_ofs,
    input logic             wr_reg,
    input logic [OFS_W-1:0] empty_ofs,
    input logic [OFS_W-1:0] full_ofs
);

    logic try_now, try_prev_q;
    assign try_now = !ld_n && !ren_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) try_prev_q <= 1'b0;
        else        try_prev_q <= try_now;
    end

    assert_b2b_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (try_now && try_prev_q) |=> !dout_valid);

    assert_b2b_err_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (try_now && try_prev_q && prst_n) |=> err_b2b);

    assert_collide_err_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_n && !wen_n && !ren_n && prst_n) |=> err_collide);

    assert_collide_noread_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_n && !wen_n && !ren_n) |=> !dout_valid);

    assert_collide_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (err_collide && prst_n) |=> err_collide);

    assert_mem_keeps_ofs_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ld_n |=> ($stable(empty_ofs) && $stable(full_ofs)));

    assert_route_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_to_mem && wr_to_ofs));

    assert_empty_invalid_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_to_ofs && !wr_reg) |=> !aempty_valid);

    assert_prst_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !prst_n |=> (!err_b2b && !err_collide && !dout_valid));

endmodule

bind offset_prog_seq offset_prog_chk #(.OFS_W(OFS_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .prst_n(prst_n), .ld_n(ld_n), .wen_n(wen_n),
    .ren_n(ren_n), .dout_valid(dout_valid), .err_b2b(err_b2b),
    .err_collide(err_collide), .aempty_valid(aempty_valid),
    .wr_to_mem(wr_to_mem), .wr_to_ofs(wr_to_ofs), .wr_reg(wptr.reg_sel),
    .empty_ofs(empty_ofs), .full_ofs(full_ofs)
);

// File: tb/offset_prog_seq_test.sv
`timescale 1ns/1ps
module offset_prog_seq_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0, prst_n = 1'b1, byte_mode = 1'b0;
    logic        ld_n = 1'b1, wen_n = 1'b1, ren_n = 1'b1;
    logic [15:0] din = '0;
    logic        wr_to_mem, rd_from_mem, wr_to_ofs, dout_valid;
    logic [15:0] dout;
    logic [23:0] empty_ofs, full_ofs;
    logic        aempty_valid, afull_valid, err_b2b, err_collide;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    offset_prog_seq uut (
        .clk(clk), .rst_n(rst_n), .prst_n(prst_n), .byte_mode(byte_mode),
        .ld_n(ld_n), .wen_n(wen_n), .ren_n(ren_n), .din(din),
        .wr_to_mem(wr_to_mem), .rd_from_mem(rd_from_mem), .wr_to_ofs(wr_to_ofs),
        .dout(dout), .dout_valid(dout_valid), .empty_ofs(empty_ofs),
        .full_ofs(full_ofs), .aempty_valid(aempty_valid), .afull_valid(afull_valid),
        .err_b2b(err_b2b), .err_collide(err_collide)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic do_reset(input logic bm);
        rst_n = 1'b0; byte_mode = bm; ld_n = 1'b1; wen_n = 1'b1; ren_n = 1'b1; prst_n = 1'b1;
        tick(); tick();
        rst_n = 1'b1;
    endtask

    task automatic ofs_write(input logic [15:0] d);
        ld_n = 1'b0; wen_n = 1'b0; din = d;
        tick();
        ld_n = 1'b1; wen_n = 1'b1;
    endtask

    task automatic ofs_read(output logic [15:0] v, output logic vld);
        ld_n = 1'b0; ren_n = 1'b0;
        tick();
        ld_n = 1'b1; ren_n = 1'b1;
        v = dout; vld = dout_valid;
        tick();
    endtask

    task automatic read_expect(input string tag, input logic [15:0] exp);
        logic [15:0] v;
        logic vld;
        ofs_read(v, vld);
        chk({tag, " valid"}, 32'(vld), 32'd1);
        chk(tag, 32'(v), 32'(exp));
    endtask

    task automatic t_reset();
        do_reset(1'b0);
        chk("R1 dout_valid", 32'(dout_valid), 32'd0);
        chk("R1 err_b2b", 32'(err_b2b), 32'd0);
        chk("R1 err_collide", 32'(err_collide), 32'd0);
        chk("R1 aempty_valid", 32'(aempty_valid), 32'd1);
        chk("R1 afull_valid", 32'(afull_valid), 32'd1);
        chk("R1 empty default", 32'(empty_ofs), 32'h030007);
        chk("R1 full default", 32'(full_ofs), 32'h050009);
        read_expect("R1 first piece", 16'h0007);
    endtask

    task automatic t_word();
        do_reset(1'b0);
        ofs_write(16'hA1B2);
        chk("R8 empty invalid mid-write", 32'(aempty_valid), 32'd0);
        ofs_write(16'hFFC3);
        chk("R8 empty invalid at last", 32'(aempty_valid), 32'd0);
        chk("R8 full unaffected", 32'(afull_valid), 32'd1);
        tick();
        chk("R8 empty invalid one edge", 32'(aempty_valid), 32'd0);
        tick();
        chk("R8 empty valid two edges", 32'(aempty_valid), 32'd1);
        ofs_write(16'h1234);
        ofs_write(16'hEE56);
        chk("R2 empty threshold", 32'(empty_ofs), 32'hC3A1B2);
        chk("R2 full threshold", 32'(full_ofs), 32'h561234);
        read_expect("R2 read E0", 16'hA1B2);
        read_expect("R2 read E1", 16'h00C3);
        read_expect("R4 read F0", 16'h1234);
        read_expect("R4 read F1", 16'h0056);
        ofs_write(16'h0001);
        chk("R2 wrap to empty", 32'(empty_ofs), 32'hC30001);
        read_expect("R4 read wrap", 16'h0001);
    endtask

    task automatic t_byte();
        do_reset(1'b1);
        ofs_write(16'hFF11); ofs_write(16'hFF22); ofs_write(16'hFF33);
        ofs_write(16'hFF44); ofs_write(16'hFF55); ofs_write(16'hFF66);
        chk("R3 empty bytes", 32'(empty_ofs), 32'h332211);
        chk("R3 full bytes", 32'(full_ofs), 32'h665544);
        read_expect("R3 read E0", 16'h0011);
        read_expect("R3 read E1", 16'h0022);
        read_expect("R3 read E2", 16'h0033);
        read_expect("R3 read F0", 16'h0044);
        read_expect("R3 read F1", 16'h0055);
        read_expect("R3 read F2", 16'h0066);
        ofs_write(16'h0077);
        chk("R3 wrap to empty", 32'(empty_ofs), 32'h332277);
        tick(); tick();
        chk("R8 full valid after byte pass", 32'(afull_valid), 32'd1);
    endtask

    task automatic t_b2b();
        do_reset(1'b0);
        ld_n = 1'b0; ren_n = 1'b0;
        tick();
        chk("R4 first read valid", 32'(dout_valid), 32'd1);
        chk("R4 first read data", 32'(dout), 32'h0007);
        tick();
        ld_n = 1'b1; ren_n = 1'b1;
        chk("R5 second read dropped", 32'(dout_valid), 32'd0);
        chk("R5 err_b2b set", 32'(err_b2b), 32'd1);
        tick(); tick();
        chk("R5 err_b2b sticky", 32'(err_b2b), 32'd1);
        read_expect("R5 pointer held", 16'h0003);
    endtask

    task automatic t_collide();
        do_reset(1'b0);
        ld_n = 1'b0; wen_n = 1'b0; ren_n = 1'b0; din = 16'hBEEF;
        tick();
        ld_n = 1'b1; wen_n = 1'b1; ren_n = 1'b1;
        chk("R6 err_collide set", 32'(err_collide), 32'd1);
        chk("R6 read ignored", 32'(dout_valid), 32'd0);
        tick();
        read_expect("R6 write landed", 16'hBEEF);
        read_expect("R6 read pointer held", 16'h0003);
        chk("R6 no b2b", 32'(err_b2b), 32'd0);
    endtask

    task automatic t_route();
        do_reset(1'b0);
        ofs_write(16'h1111);
        ld_n = 1'b1; wen_n = 1'b0; ren_n = 1'b0; din = 16'h2222;
        #1;
        chk("R7 wr_to_mem", 32'(wr_to_mem), 32'd1);
        chk("R7 rd_from_mem", 32'(rd_from_mem), 32'd1);
        chk("R7 wr_to_ofs low", 32'(wr_to_ofs), 32'd0);
        tick(); tick();
        wen_n = 1'b1; ren_n = 1'b1;
        chk("R7 no readback for mem read", 32'(dout_valid), 32'd0);
        chk("R7 empty untouched", 32'(empty_ofs), 32'h031111);
        ld_n = 1'b0; wen_n = 1'b0; din = 16'h0044;
        #1;
        chk("R7 wr_to_ofs", 32'(wr_to_ofs), 32'd1);
        chk("R7 wr_to_mem low", 32'(wr_to_mem), 32'd0);
        tick();
        ld_n = 1'b1; wen_n = 1'b1;
        read_expect("R10 read starts at E0", 16'h1111);
        read_expect("R7 resumed at E1", 16'h0044);
    endtask

    task automatic t_prst();
        do_reset(1'b0);
        ofs_write(16'h5555);
        ld_n = 1'b0; wen_n = 1'b0; ren_n = 1'b0; din = 16'h0066;
        tick();
        ld_n = 1'b1; wen_n = 1'b1; ren_n = 1'b1;
        tick();
        read_expect("R9 pre read", 16'h5555);
        prst_n = 1'b0;
        tick();
        prst_n = 1'b1;
        chk("R9 err_collide cleared", 32'(err_collide), 32'd0);
        chk("R9 thresholds kept", 32'(empty_ofs), 32'h665555);
        ofs_write(16'h7777);
        chk("R9 write pointer kept", 32'(full_ofs), 32'h057777);
        read_expect("R9 read pointer kept", 16'h0066);
        read_expect("R10 read follows", 16'h7777);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_word();
        t_byte();
        t_b2b();
        t_collide();
        t_route();
        t_prst();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule